// File: doc/BRIEF.md
# Resonant Half-Bridge Zero-Current-Switching Guard

This block watches every conduction interval of a resonant half-bridge. It sits between the gate commands from the timing logic and the gate drivers. Each leg has two digital comparator inputs. The first reports that the sensed tank current has dropped under the zero-current level for that leg's polarity. The second reports that the resonant-capacitor voltage has reached its normal switching threshold. Either comparator can end the active gate pulse. When a current-under-threshold reading counts as a real falling edge, the gate is cut at once, ahead of the normal voltage-threshold end, so that enough tank current is left to drive the soft transition in the dead time.

Both comparators are ignored for a programmable blanking window after each gate rising edge. A current reading is accepted only after the current has been seen above the threshold for two clean cycles. Every accepted cut sends a one-cycle request that makes the external soft-start ramp step down, which raises the switching frequency. A run of switching periods that each contain a cut is timed. If the run lasts the programmed duration, a latched fault forces both gates low.

Top module: `zcs_guard`

## Requirements
- R1: During a high-side interval (`hs_cmd` high), an accepted current-under-threshold reading (`hs_cs_low` = 1) drives `hs_gate` low in that same cycle and pulses `hs_zcs_cut` for exactly that cycle. `hs_gate` stays low until `hs_cmd` falls. Before the cut, `hs_gate` follows `hs_cmd`.
- R2: The low side behaves the same way with `ls_cmd`, `ls_cs_low`, `ls_vcr_hit`, `ls_gate` and `ls_zcs_cut`.
- R3: In each interval, the first BLANK_CYC cycles are blanked, counting the cycle in which the command rises as the first. In those cycles both the current and the voltage comparator of that leg are ignored. BLANK_CYC must be at least 1.
- R4: A current-under-threshold reading is accepted only after at least 2 consecutive unblanked cycles with the comparator at 0. An unblanked 1 seen before that restarts the count and is not a cut.
- R5: An unblanked `*_vcr_hit` = 1 ends the gate in that cycle without a cut pulse. If it coincides with an accepted current reading, the end counts as a cut.
- R6: Each interval has at most one end, whether cut or voltage. A gate is never high while its command is low.
- R7: `ss_ramp_down` is a one-cycle pulse in the cycle after each cut on either leg.
- R8: A run begins with a cut. It continues while every switching period contains at least one cut, where a switching period runs from one `hs_cmd` rising edge to the next. If the run is unbroken, `zcs_fault` rises FAULT_CYC+1 cycles after the cycle of the run's first cut.
- R9: At a `hs_cmd` rising edge that closes a period with no cut, the run timer goes back to zero. A run broken this way produces no fault.
- R10: While `zcs_fault` is high, both gates are held low and no cut is issued. The fault stays until `clr_fault` is sampled high (synchronous), which also clears the run timer. Reset clears it as well.
- R11: In reset, and on the first cycle after it with commands low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_fault | input | 1 | Synchronous fault clear |
| hs_cmd | input | 1 | High-side gate command |
| ls_cmd | input | 1 | Low-side gate command |
| hs_cs_low | input | 1 | Current under zero-current level, high-side polarity |
| ls_cs_low | input | 1 | Current under zero-current level, low-side polarity |
| hs_vcr_hit | input | 1 | Capacitor voltage at high-side end threshold |
| ls_vcr_hit | input | 1 | Capacitor voltage at low-side end threshold |
| hs_gate | output | 1 | High-side gate drive |
| ls_gate | output | 1 | Low-side gate drive |
| hs_zcs_cut | output | 1 | High-side early-cut pulse |
| ls_zcs_cut | output | 1 | Low-side early-cut pulse |
| ss_ramp_down | output | 1 | Soft-start decrease request |
| zcs_fault | output | 1 | Latched persistent-event fault |

## Verification
A wrong blanking counter or qualification count shows up within the same interval as a gate that drops one or more cycles early or late, or as a cut pulse at the wrong position. The bench therefore sweeps the trip position, an initial under-threshold stretch and the voltage-hit position for both legs, and compares every cycle. A wrong run-tracking state is silent for a long time. It appears only as a fault that arrives too early, too late or not at all, FAULT_CYC+1 cycles after the first cut, or as a missing clear after an event-free period. Those cases are therefore checked by measuring the exact cycle distance.

// File: rtl/zcs_pkg.sv
// Shared widths for the zero-current-switching guard.
// Assumes: the blanking count fits 16 bits and the fault duration 24 bits.
package zcs_pkg;
    localparam int BLANK_W  = 16;
    localparam int FAULT_W  = 24;
    localparam int QUAL_CYC = 2;
    localparam int QUAL_W   = $clog2(QUAL_CYC + 1);
endpackage

// File: rtl/zcs_leg.sv
// One half-bridge leg: blanks the comparators after the command rises,
// qualifies the current falling edge and ends the gate early or on the
// capacitor-voltage hit.
// Assumes: cmd_i is the gate command of this leg, BLANK_CYC >= 1.
module zcs_leg #(
    parameter logic [zcs_pkg::BLANK_W-1:0] BLANK_CYC = 16'd8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic cs_low_i,
    input  logic vcr_hit_i,
    input  logic inhibit_i,
    output logic gate_o,
    output logic cut_o
);
    import zcs_pkg::*;

    logic [BLANK_W-1:0] on_cnt_q;
    logic [QUAL_W-1:0]  above_q;
    logic               done_q;
    logic               active, blanked, armed, vend;

    // Purpose: decide blanking, arming and the end of the current interval.
    always_comb begin
        active  = cmd_i & ~inhibit_i;
        blanked = (on_cnt_q < BLANK_CYC);
        armed   = (above_q == QUAL_W'(QUAL_CYC));
        cut_o   = active & ~blanked & armed & cs_low_i & ~done_q;
        vend    = active & ~blanked & vcr_hit_i & ~done_q & ~cut_o;
        gate_o  = active & ~done_q & ~cut_o & ~vend;
    end

    // Purpose: track interval age, clean-above count and the ended flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !cmd_i) begin
            on_cnt_q <= '0;
            above_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            if (blanked)
                on_cnt_q <= on_cnt_q + 1'b1;
            if (!blanked && !armed)
                above_q <= cs_low_i ? '0 : above_q + QUAL_W'(1);
            if (cut_o || vend)
                done_q <= 1'b1;
        end
    end

    // R3: the rising cycle is always blanked
    a_r3_rise_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_i) |-> !cut_o && gate_o == !inhibit_i);
    // R4: two clean cycles precede every cut
    a_r4_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        cut_o |-> $past(!cs_low_i) && $past(!cs_low_i, 2));
    // R1: gate stays low after a cut
    a_r1_cut_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cut_o |=> !gate_o);
    // R6: one end per interval
    a_r6_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_o || vend) |=> !cut_o);
    // R6: no gate without command
    a_r6_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> cmd_i);
endmodule

// File: rtl/zcs_persist.sv
// Times runs of switching periods that each contain a cut and latches the
// fault when a run reaches FAULT_CYC cycles.
// Assumes: a switching period starts at each high-side command rising edge.
module zcs_persist #(
    parameter logic [zcs_pkg::FAULT_W-1:0] FAULT_CYC = 24'd100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic hs_cmd_i,
    input  logic cut_any_i,
    output logic fault_o
);
    import zcs_pkg::*;

    localparam logic [FAULT_W-1:0] TMR_LAST = FAULT_CYC - 24'd1;

    logic               hs_q, seen_q, run_q, fault_q;
    logic [FAULT_W-1:0] tmr_q;
    logic               period_edge, break_run, hit_last;

    // Purpose: find period boundaries and whether the run breaks there.
    always_comb begin
        period_edge = hs_cmd_i & ~hs_q;
        break_run   = period_edge & ~seen_q;
        hit_last    = run_q & ~fault_q & ~break_run & (tmr_q == TMR_LAST);
        fault_o     = fault_q;
    end

    // Purpose: remember the previous high-side command level.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hs_cmd_i;
    end

    // Purpose: per-period event flag, run timer and fault latch.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            seen_q  <= 1'b0;
            run_q   <= 1'b0;
            tmr_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (period_edge)    seen_q <= cut_any_i;
            else if (cut_any_i) seen_q <= 1'b1;

            if (break_run)      run_q <= 1'b0;
            else if (cut_any_i) run_q <= 1'b1;

            if (break_run)
                tmr_q <= '0;
            else if (run_q && !fault_q && !hit_last)
                tmr_q <= tmr_q + 1'b1;

            if (hit_last) fault_q <= 1'b1;
        end
    end

    // R10: fault latched until clear
    a_r10_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && !clr_i |=> fault_q);
    // R8: fault only rises out of a running timer
    a_r8_fault_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(run_q));
    // R8: timer never passes its limit
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q < FAULT_CYC);
    // R9: empty period resets the timer
    a_r9_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        break_run |=> tmr_q == '0);
endmodule

// File: rtl/zcs_guard.sv
// Top: two legs plus the persistence timer; emits gate drives, cut pulses,
// the soft-start decrease request and the latched fault.
// Assumes: the two gate commands never overlap (dead time is upstream).
module zcs_guard #(
    parameter logic [zcs_pkg::BLANK_W-1:0] BLANK_CYC = 16'd8,
    parameter logic [zcs_pkg::FAULT_W-1:0] FAULT_CYC = 24'd100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_fault,
    input  logic hs_cmd,
    input  logic ls_cmd,
    input  logic hs_cs_low,
    input  logic ls_cs_low,
    input  logic hs_vcr_hit,
    input  logic ls_vcr_hit,
    output logic hs_gate,
    output logic ls_gate,
    output logic hs_zcs_cut,
    output logic ls_zcs_cut,
    output logic ss_ramp_down,
    output logic zcs_fault
);
    localparam int LEGS = 2;

    logic [LEGS-1:0] cmd_w, low_w, vcr_w, gate_w, cut_w;
    logic            fault_w, cut_any, ss_q;

    assign cmd_w   = {ls_cmd, hs_cmd};
    assign low_w   = {ls_cs_low, hs_cs_low};
    assign vcr_w   = {ls_vcr_hit, hs_vcr_hit};
    assign cut_any = |cut_w;

    for (genvar s = 0; s < LEGS; s++) begin : g_leg
        zcs_leg #(.BLANK_CYC(BLANK_CYC)) leg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_i     (cmd_w[s]),
            .cs_low_i  (low_w[s]),
            .vcr_hit_i (vcr_w[s]),
            .inhibit_i (fault_w),
            .gate_o    (gate_w[s]),
            .cut_o     (cut_w[s])
        );
    end

    zcs_persist #(.FAULT_CYC(FAULT_CYC)) persist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_fault),
        .hs_cmd_i  (hs_cmd),
        .cut_any_i (cut_any),
        .fault_o   (fault_w)
    );

    // Purpose: register the soft-start decrease request one cycle after a cut.
    always_ff @(posedge clk) begin
        if (!rst_n) ss_q <= 1'b0;
        else        ss_q <= cut_any;
    end

    assign hs_gate      = gate_w[0];
    assign ls_gate      = gate_w[1];
    assign hs_zcs_cut   = cut_w[0];
    assign ls_zcs_cut   = cut_w[1];
    assign ss_ramp_down = ss_q;
    assign zcs_fault    = fault_w;

    // R10: fault forces both gates off
    a_r10_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        zcs_fault |-> !hs_gate && !ls_gate && !hs_zcs_cut && !ls_zcs_cut);
    // R7: each request follows a cut
    a_r7_ramp_follows_cut: assert property (@(posedge clk) disable iff (!rst_n)
        ss_ramp_down |-> $past(hs_zcs_cut || ls_zcs_cut));
    // R7: each cut yields a request
    a_r7_cut_gives_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_zcs_cut || ls_zcs_cut) |=> ss_ramp_down);
endmodule

// File: tb/zcs_guard_tb_top.sv
module zcs_guard_tb_top;
    localparam int BL = 3;
    localparam int FL = 48;

    logic clk = 1'b0;
    logic rst_n, clr_fault, hs_cmd, ls_cmd, hs_cs_low, ls_cs_low, hs_vcr_hit, ls_vcr_hit;
    logic hs_gate, ls_gate, hs_zcs_cut, ls_zcs_cut, ss_ramp_down, zcs_fault;

    int checks = 0, errors = 0, cyc = 0, first_ev = -1, fault_cyc = -1;
    bit fault_seen = 0;
    bit prev_cut = 0;

    always #5 clk = ~clk;

    zcs_guard #(.BLANK_CYC(16'(BL)), .FAULT_CYC(24'(FL))) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_fault(clr_fault),
        .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
        .hs_cs_low(hs_cs_low), .ls_cs_low(ls_cs_low),
        .hs_vcr_hit(hs_vcr_hit), .ls_vcr_hit(ls_vcr_hit),
        .hs_gate(hs_gate), .ls_gate(ls_gate),
        .hs_zcs_cut(hs_zcs_cut), .ls_zcs_cut(ls_zcs_cut),
        .ss_ramp_down(ss_ramp_down), .zcs_fault(zcs_fault));

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    // Drive one cycle's inputs after the edge, then sample mid-cycle.
    task automatic tick(input logic h, input logic l, input logic hc, input logic lc,
                        input logic hv, input logic lv, input logic cl);
        @(posedge clk);
        #2;
        hs_cmd = h; ls_cmd = l; hs_cs_low = hc; ls_cs_low = lc;
        hs_vcr_hit = hv; ls_vcr_hit = lv; clr_fault = cl;
        #3;
        cyc++;
        if (zcs_fault && !fault_seen) begin fault_seen = 1; fault_cyc = cyc; end
        if ((hs_zcs_cut || ls_zcs_cut) && first_ev < 0) first_ev = cyc;
    endtask

    // Expected cut position from the blanking and two-clean-cycle rule (R3, R4).
    function automatic int exp_zcs(input int pre, input int trip, input int len);
        int cnt = 0;
        for (int k = BL; k < len; k++) begin
            bit b = (k < pre) || (k >= trip);
            if (cnt >= 2 && b) return k;
            if (b) cnt = 0; else cnt++;
        end
        return 999;
    endfunction

    task automatic idle(input int n, input logic cl, input bit chk);
        for (int i = 0; i < n; i++) begin
            tick(0, 0, 0, 0, 0, 0, cl);
            if (chk) begin
                check("R6", "hs_gate idle", hs_gate, 0);
                check("R6", "ls_gate idle", ls_gate, 0);
                check("R7", "ss_ramp_down", ss_ramp_down, prev_cut);
            end
            prev_cut = 0;
        end
    endtask

    task automatic leg(input int side, input int len, input int pre, input int trip,
                       input int vat, input bit chk);
        int zk, vk, cutk, endk;
        string tag;
        zk   = exp_zcs(pre, trip, len);
        vk   = (vat >= len) ? 999 : ((vat < BL) ? BL : vat);
        cutk = (zk <= vk) ? zk : 999;
        endk = (zk < vk) ? zk : vk;
        if (vk < zk)          tag = "R5";
        else if (pre > 0)     tag = "R4";
        else if (trip < BL)   tag = "R3";
        else                  tag = (side == 0) ? "R1" : "R2";
        for (int k = 0; k < len; k++) begin
            bit b = (k < pre) || (k >= trip);
            bit v = (k >= vat);
            if (side == 0) tick(1, 0, b, 0, v, 0, 0);
            else           tick(0, 1, 0, b, 0, v, 0);
            if (chk) begin
                check(tag, "own gate", side ? ls_gate : hs_gate, int'(k < endk));
                check(tag, "own cut", side ? ls_zcs_cut : hs_zcs_cut, int'(k == cutk));
                check("R6", "other gate", side ? hs_gate : ls_gate, 0);
                check("R7", "ss_ramp_down", ss_ramp_down, prev_cut);
            end
            prev_cut = (k == cutk);
        end
    endtask

    task automatic fault_run();
        idle(1, 1, 0);
        first_ev = -1; fault_seen = 0; fault_cyc = -1;
        for (int p = 0; p < 4; p++) begin
            leg(0, 10, 0, 6, 99, 0); idle(1, 0, 0);
            leg(1, 10, 0, 6, 99, 0); idle(1, 0, 0);
        end
    endtask

    initial begin
        int vats[3] = '{1, 7, 99};
        int pres[4] = '{0, 2, 4, 5};
        rst_n = 0; clr_fault = 0; hs_cmd = 0; ls_cmd = 0;
        hs_cs_low = 0; ls_cs_low = 0; hs_vcr_hit = 0; ls_vcr_hit = 0;
        repeat (3) @(posedge clk);
        #5;
        // R11: reset state
        check("R11", "hs_gate reset", hs_gate, 0);
        check("R11", "ls_gate reset", ls_gate, 0);
        check("R11", "fault reset", zcs_fault, 0);
        check("R11", "ss reset", ss_ramp_down, 0);
        @(posedge clk); #2; rst_n = 1;
        idle(1, 0, 1);
        check("R11", "fault after reset", zcs_fault, 0);

        // R1 R2 R3 R4 R5 R6 R7: sweep trip point, early-low stretch and voltage hit
        for (int s = 0; s < 2; s++)
            foreach (pres[p])
                for (int t = 0; t < 11; t++)
                    foreach (vats[v]) begin
                        idle(1, 1, 1);
                        leg(s, 12, pres[p], t, vats[v], 1);
                        idle(1, 0, 1);
                    end

        // R9: a run broken by an empty period never faults
        idle(1, 1, 1);
        first_ev = -1; fault_seen = 0;
        leg(0, 10, 0, 6, 99, 1); idle(1, 0, 1); leg(1, 10, 0, 99, 99, 1); idle(1, 0, 1);
        for (int p = 0; p < 3; p++) begin
            leg(0, 10, 0, 99, 99, 1); idle(1, 0, 1); leg(1, 10, 0, 99, 99, 1); idle(1, 0, 1);
        end
        idle(60, 0, 1);
        check("R9", "fault after broken run", int'(fault_seen), 0);

        // R8: unbroken run faults FAULT_CYC+1 cycles after the first cut
        fault_run();
        check("R8", "fault seen", int'(fault_seen), 1);
        check("R8", "fault distance", fault_cyc - first_ev, FL + 1);

        // R10: gates held low and no cut while faulted
        for (int k = 0; k < 12; k++) begin
            tick(1, 0, int'(k >= 6), 0, int'(k >= 9), 0, 0);
            check("R10", "hs_gate in fault", hs_gate, 0);
            check("R10", "hs_cut in fault", hs_zcs_cut, 0);
            check("R10", "fault held", zcs_fault, 1);
        end
        idle(2, 0, 0);
        check("R10", "fault held idle", zcs_fault, 1);
        idle(1, 1, 0);
        check("R10", "fault during clear cycle", zcs_fault, 1);
        idle(1, 0, 1);
        check("R10", "fault after clear", zcs_fault, 0);
        leg(0, 12, 0, 7, 99, 1);
        idle(1, 0, 1);

        // R10: reset also clears the fault
        fault_run();
        check("R10", "fault before reset", zcs_fault, 1);
        @(posedge clk); #2; rst_n = 0;
        @(posedge clk); #2; rst_n = 1; #3;
        check("R10", "fault after reset", zcs_fault, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule